// File: doc/BRIEF.md
# DDR2 Bank State Timing Tracker

This block observes a decoded DDR2 command stream, one command per clock, and keeps a running picture of every bank. For each of eight banks it holds a state (idle, activating, row active or precharging) and a down-counter. The counter times the transient states out to their configured cycle counts. A separate global timer covers the two operations that apply to the whole device: refresh and mode-register loading. Any command that the current state does not allow is flagged on a one-cycle error output and has no effect on the tracked state.

The command input has no valid/ready handshake and applies no back-pressure. The tracker accepts a command on every clock, and a slot with nothing to do carries NOP or DESELECT. The tracker never stalls the stream. A controller or a protocol monitor can use the state outputs to schedule commands, or use the error pulse to find sequencing faults. The timing values (activate-to-access, precharge, refresh and mode-load times) are parameters counted in clock cycles, each at least 1.

Top module: `ddr2trk_top`

## Requirements
- R1: Encodings are as follows. cmd_i is NOP=0, DESELECT=1, ACTIVATE=2, READ=3, WRITE=4, PRECHARGE=5, PRECHARGE ALL=6, REFRESH=7, LOAD MODE=8, and ap_i selects auto precharge. Bank b's state is on bank_state_o[2b+1:2b] as idle=0, activating=1, row active=2, precharging=3. gbl_mode_o is none=0, refresh=1, mode load=2. After reset every bank is idle, gbl_mode_o is 0 and cmd_err_o is low.
- R2: ACTIVATE to an idle bank makes that bank read activating for T_RCD cycles, starting in the cycle after the command. The bank then reads row active.
- R3: PRECHARGE to a row-active bank makes that bank read precharging for T_RP cycles and then idle. PRECHARGE to an idle bank changes nothing and is not an error.
- R4: READ or WRITE with ap_i=1 to a row-active bank makes that bank read precharging for T_RP cycles and then idle. With ap_i=0 the bank stays row active.
- R5: READ or WRITE to a bank that is not row active is an error.
- R6: PRECHARGE ALL, when every bank is idle or row active, makes every bank read precharging for T_RP cycles and then idle.
- R7: PRECHARGE ALL while any bank is activating or precharging is an error.
- R8: REFRESH with all banks idle makes gbl_mode_o read 1 for T_RFC cycles. LOAD MODE with all banks idle makes it read 2 for T_MRD cycles. In both cases all banks stay idle throughout.
- R9: REFRESH or LOAD MODE while any bank is not idle is an error.
- R10: While gbl_mode_o is non-zero, every command other than NOP or DESELECT is an error.
- R11: ACTIVATE to a bank that is not idle is an error, and so is PRECHARGE to an activating or precharging bank. Commands to other banks are still accepted while one bank times out, and each bank's timer runs on its own.
- R12: Command codes 9 to 15 are errors.
- R13: An erroneous command raises cmd_err_o for exactly the next cycle and changes no bank state and no global state. Running timers continue to count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands register on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 4 | Decoded command code |
| ap_i | input | 1 | Auto precharge for READ/WRITE |
| ba_i | input | 3 | Target bank address |
| bank_state_o | output | 16 | Two-bit state per bank, bank 0 in the low bits |
| gbl_mode_o | output | 2 | Global busy state (none, refresh, mode load) |
| cmd_err_o | output | 1 | One-cycle pulse after an illegal command |

## Verification
On every cycle, the assertions check these local rules: a busy global state forbids executable commands and implies all banks idle. An access to a bank that is not row active, or an unused code, is followed by the error pulse. A legal ACTIVATE or REFRESH enters the right state. An activating bank can only stay or become row active, and a precharging bank can only stay or become idle. The exact lengths of the transient windows, the fact that illegal commands leave state untouched, and the independence of timers across banks under interleaved commands are shown only by the bench's scenarios. There, a behavioural model is compared on each clock.

// File: rtl/ddr2trk_pkg.sv
package ddr2trk_pkg;

  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_DESEL = 4'd1,
    CMD_ACT   = 4'd2,
    CMD_RD    = 4'd3,
    CMD_WR    = 4'd4,
    CMD_PRE   = 4'd5,
    CMD_PREA  = 4'd6,
    CMD_REF   = 4'd7,
    CMD_LMR   = 4'd8
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE = 2'd0,
    BK_ACTV = 2'd1,
    BK_ROW  = 2'd2,
    BK_PRE  = 2'd3
  } bank_st_e;

  typedef enum logic [1:0] {
    GB_NONE = 2'd0,
    GB_REF  = 2'd1,
    GB_MRS  = 2'd2
  } gbl_st_e;

endpackage

// File: rtl/ddr2trk_legal.sv
module ddr2trk_legal
  import ddr2trk_pkg::*;
#(
  parameter int NB   = 8,
  parameter int BA_W = 3
) (
  input  logic [3:0]         cmd,
  input  logic               ap,
  input  logic [BA_W-1:0]    ba,
  input  logic [NB-1:0][1:0] bst,
  input  logic [1:0]         gst,
  output logic               bad,
  output logic [NB-1:0]      act_go,
  output logic [NB-1:0]      pre_go,
  output logic               ref_go,
  output logic               mrs_go
);

  logic       any_trans;
  logic       all_idle;
  logic [1:0] tgt;
  logic       quiet;

  always_comb begin
    any_trans = 1'b0;
    all_idle  = 1'b1;
    for (int i = 0; i < NB; i++) begin
      if (bst[i] == BK_ACTV || bst[i] == BK_PRE) any_trans = 1'b1;
      if (bst[i] != BK_IDLE) all_idle = 1'b0;
    end
  end

  assign tgt   = bst[ba];
  assign quiet = (cmd == CMD_NOP) || (cmd == CMD_DESEL);

  always_comb begin
    bad    = 1'b0;
    act_go = '0;
    pre_go = '0;
    ref_go = 1'b0;
    mrs_go = 1'b0;
    if (gst != GB_NONE) begin
      bad = !quiet;
    end else begin
      case (cmd)
        CMD_NOP, CMD_DESEL: ;
        CMD_ACT: begin
          if (tgt == BK_IDLE) act_go[ba] = 1'b1;
          else                bad = 1'b1;
        end
        CMD_RD, CMD_WR: begin
          if (tgt == BK_ROW) pre_go[ba] = ap;
          else               bad = 1'b1;
        end
        CMD_PRE: begin
          if (tgt == BK_ROW)       pre_go[ba] = 1'b1;
          else if (tgt != BK_IDLE) bad = 1'b1;
        end
        CMD_PREA: begin
          if (any_trans) bad = 1'b1;
          else           pre_go = '1;
        end
        CMD_REF: begin
          if (all_idle) ref_go = 1'b1;
          else          bad = 1'b1;
        end
        CMD_LMR: begin
          if (all_idle) mrs_go = 1'b1;
          else          bad = 1'b1;
        end
        default: bad = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/ddr2trk_bank.sv
module ddr2trk_bank
  import ddr2trk_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_act,
  input  logic       go_pre,
  output logic [1:0] state_o
);

  localparam int TMAX = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int CW   = $clog2(TMAX + 1);

  bank_st_e st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= BK_IDLE;
      cnt <= '0;
    end else if (go_act) begin
      st  <= BK_ACTV;
      cnt <= CW'(T_RCD - 1);
    end else if (go_pre) begin
      st  <= BK_PRE;
      cnt <= CW'(T_RP - 1);
    end else if (st == BK_ACTV || st == BK_PRE) begin
      if (cnt == '0) st <= (st == BK_ACTV) ? BK_ROW : BK_IDLE;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign state_o = st;

endmodule

// File: rtl/ddr2trk_global.sv
module ddr2trk_global
  import ddr2trk_pkg::*;
#(
  parameter int T_RFC = 12,
  parameter int T_MRD = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_ref,
  input  logic       go_mrs,
  output logic [1:0] mode_o
);

  localparam int TMAX = (T_RFC > T_MRD) ? T_RFC : T_MRD;
  localparam int CW   = $clog2(TMAX + 1);

  gbl_st_e gs;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gs  <= GB_NONE;
      cnt <= '0;
    end else if (go_ref) begin
      gs  <= GB_REF;
      cnt <= CW'(T_RFC - 1);
    end else if (go_mrs) begin
      gs  <= GB_MRS;
      cnt <= CW'(T_MRD - 1);
    end else if (gs != GB_NONE) begin
      if (cnt == '0) gs <= GB_NONE;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign mode_o = gs;

endmodule

// File: rtl/ddr2trk_top.sv
module ddr2trk_top
  import ddr2trk_pkg::*;
#(
  parameter int NB    = 8,
  parameter int T_RCD = 3,
  parameter int T_RP  = 4,
  parameter int T_RFC = 12,
  parameter int T_MRD = 2,
  localparam int BA_W = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      cmd_i,
  input  logic            ap_i,
  input  logic [BA_W-1:0] ba_i,
  output logic [2*NB-1:0] bank_state_o,
  output logic [1:0]      gbl_mode_o,
  output logic            cmd_err_o
);

  logic [NB-1:0][1:0] bst;
  logic [NB-1:0]      act_go;
  logic [NB-1:0]      pre_go;
  logic               ref_go;
  logic               mrs_go;
  logic               bad;

  ddr2trk_legal #(.NB(NB), .BA_W(BA_W)) u_legal (
    .cmd    (cmd_i),
    .ap     (ap_i),
    .ba     (ba_i),
    .bst    (bst),
    .gst    (gbl_mode_o),
    .bad    (bad),
    .act_go (act_go),
    .pre_go (pre_go),
    .ref_go (ref_go),
    .mrs_go (mrs_go)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    ddr2trk_bank #(.T_RCD(T_RCD), .T_RP(T_RP)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_act  (act_go[g]),
      .go_pre  (pre_go[g]),
      .state_o (bst[g])
    );
  end

  ddr2trk_global #(.T_RFC(T_RFC), .T_MRD(T_MRD)) u_gbl (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_ref (ref_go),
    .go_mrs (mrs_go),
    .mode_o (gbl_mode_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_err_o <= 1'b0;
    else        cmd_err_o <= bad;
  end

  assign bank_state_o = bst;

endmodule

// File: rtl/ddr2trk_chk.sv
module ddr2trk_chk
  import ddr2trk_pkg::*;
#(
  parameter int NB   = 8,
  parameter int BA_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      cmd_i,
  input logic [BA_W-1:0] ba_i,
  input logic [2*NB-1:0] bank_state_o,
  input logic [1:0]      gbl_mode_o,
  input logic            cmd_err_o
);

  logic [1:0]      bs [NB];
  logic [BA_W-1:0] ba_q;
  logic            quiet;
  logic            idle_all;

  always_comb begin
    for (int i = 0; i < NB; i++) bs[i] = bank_state_o[2*i +: 2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ba_q <= '0;
    else        ba_q <= ba_i;
  end

  assign quiet    = (cmd_i == CMD_NOP) || (cmd_i == CMD_DESEL);
  assign idle_all = (bank_state_o == '0);

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (gbl_mode_o != GB_NONE && !quiet) |=> cmd_err_o);  // R10

  AST_BUSY_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (gbl_mode_o != GB_NONE) |-> idle_all);  // R8

  AST_REF_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (gbl_mode_o == GB_NONE && cmd_i == CMD_REF && idle_all) |=> (gbl_mode_o == GB_REF));  // R8

  AST_RW_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (gbl_mode_o == GB_NONE && (cmd_i == CMD_RD || cmd_i == CMD_WR) && bs[ba_i] != BK_ROW)
    |=> cmd_err_o);  // R5

  AST_ACT_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (gbl_mode_o == GB_NONE && cmd_i == CMD_ACT && bs[ba_i] == BK_IDLE)
    |=> (bs[ba_q] == BK_ACTV && !cmd_err_o));  // R2

  AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i > CMD_LMR) |=> cmd_err_o);  // R12

  for (genvar g = 0; g < NB; g++) begin : g_seq
    AST_ACTV_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (bs[g] == BK_ACTV) |=> (bs[g] == BK_ACTV || bs[g] == BK_ROW));  // R2
    AST_PRE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (bs[g] == BK_PRE) |=> (bs[g] == BK_PRE || bs[g] == BK_IDLE));  // R3
  end

endmodule

bind ddr2trk_top ddr2trk_chk #(.NB(NB), .BA_W(BA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_i        (cmd_i),
  .ba_i         (ba_i),
  .bank_state_o (bank_state_o),
  .gbl_mode_o   (gbl_mode_o),
  .cmd_err_o    (cmd_err_o)
);

// File: tb/ddr2trk_top_tb_top.sv
module ddr2trk_top_tb_top;

  localparam int NB    = 8;
  localparam int T_RCD = 3;
  localparam int T_RP  = 4;
  localparam int T_RFC = 12;
  localparam int T_MRD = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cmd_i = 4'd0;
  logic        ap_i = 1'b0;
  logic [2:0]  ba_i = 3'd0;
  logic [15:0] bank_state_o;
  logic [1:0]  gbl_mode_o;
  logic        cmd_err_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference: state and cycles still to go
  int st [NB];
  int rem [NB];
  int gm = 0;
  int grem = 0;
  bit m_err = 0;

  ddr2trk_top #(.NB(NB), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .ap_i(ap_i), .ba_i(ba_i),
    .bank_state_o(bank_state_o), .gbl_mode_o(gbl_mode_o), .cmd_err_o(cmd_err_o)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0d exp=%0d", cur_req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin st[b] = 0; rem[b] = 0; end
      gm = 0; grem = 0; m_err = 0;
    end else begin
      int ost [NB];
      int c;
      int b;
      bit bad;
      bit busy;
      bit any_t;
      bit any_nz;
      c = int'(cmd_i); b = int'(ba_i); bad = 0;
      busy = (gm != 0);
      any_t = 0; any_nz = 0;
      for (int k = 0; k < NB; k++) begin
        ost[k] = st[k];
        if (st[k] == 1 || st[k] == 3) any_t = 1;
        if (st[k] != 0) any_nz = 1;
      end
      // time passes for everyone
      for (int k = 0; k < NB; k++) begin
        if (st[k] == 1 || st[k] == 3) begin
          rem[k]--;
          if (rem[k] == 0) st[k] = (st[k] == 1) ? 2 : 0;
        end
      end
      if (gm != 0) begin
        grem--;
        if (grem == 0) gm = 0;
      end
      if (busy) begin
        bad = !(c == 0 || c == 1);
      end else begin
        case (c)
          0, 1: ;
          2: if (ost[b] == 0) begin st[b] = 1; rem[b] = T_RCD; end else bad = 1;
          3, 4: if (ost[b] == 2) begin
                  if (ap_i) begin st[b] = 3; rem[b] = T_RP; end
                end else bad = 1;
          5: if (ost[b] == 2) begin st[b] = 3; rem[b] = T_RP; end
             else if (ost[b] != 0) bad = 1;
          6: if (any_t) bad = 1;
             else for (int k = 0; k < NB; k++) begin st[k] = 3; rem[k] = T_RP; end
          7: if (any_nz) bad = 1; else begin gm = 1; grem = T_RFC; end
          8: if (any_nz) bad = 1; else begin gm = 2; grem = T_MRD; end
          default: bad = 1;
        endcase
      end
      m_err = bad;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int b = 0; b < NB; b++)
        chk(int'(bank_state_o[2*b +: 2]) == st[b], $sformatf("bank%0d state", b),
            int'(bank_state_o[2*b +: 2]), st[b]);
      chk(int'(gbl_mode_o) == gm, "global mode", int'(gbl_mode_o), gm);
      chk(cmd_err_o == m_err, "error flag", int'(cmd_err_o), int'(m_err));  // R13
    end
    if (cyc > 20000 && !done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
      finish_run();
    end
  end

  task automatic issue(input int c, input int b, input bit a);
    @(negedge clk);
    cmd_i = 4'(c); ba_i = 3'(b); ap_i = a;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    cur_req = "R1";
    chk(bank_state_o == '0, "banks after reset", int'(bank_state_o), 0);
    chk(gbl_mode_o == 2'd0, "global after reset", int'(gbl_mode_o), 0);
    chk(cmd_err_o == 1'b0, "error after reset", int'(cmd_err_o), 0);

    cur_req = "R2";  issue(2, 0, 0); idle(4);
    cur_req = "R4";  issue(3, 0, 0); issue(4, 0, 0); idle(1); issue(4, 0, 1); idle(5);
    cur_req = "R3";  issue(2, 2, 0); idle(3); issue(5, 2, 0); idle(5); issue(5, 5, 0); idle(1);
    cur_req = "R5";  issue(3, 1, 0); issue(4, 1, 1); idle(1);
    cur_req = "R11"; issue(2, 3, 0); issue(2, 3, 0); issue(5, 3, 0); issue(3, 3, 0);
                     issue(2, 4, 0); idle(4); issue(5, 3, 0); issue(5, 4, 0); idle(5);
    cur_req = "R7";  issue(2, 6, 0); issue(6, 0, 0); idle(4);
    cur_req = "R6";  issue(2, 1, 0); idle(3); issue(6, 0, 0); idle(5);
    cur_req = "R9";  issue(2, 7, 0); idle(3); issue(7, 0, 0); issue(8, 0, 0);
                     issue(5, 7, 0); idle(5);
    cur_req = "R8";  issue(7, 0, 0); idle(12); issue(8, 0, 0); idle(3);
    cur_req = "R10"; issue(7, 0, 0); issue(2, 0, 0); issue(1, 0, 0); issue(3, 0, 0);
                     issue(6, 0, 0); issue(7, 0, 0); idle(12); issue(8, 0, 0);
                     issue(8, 0, 0); issue(1, 0, 0); idle(2);
    cur_req = "R12"; issue(9, 0, 0); issue(15, 2, 1); issue(2, 5, 0); issue(12, 5, 0); idle(5);
    cur_req = "R13"; issue(2, 0, 0); issue(2, 0, 0); issue(7, 0, 0); idle(5);
    idle(2);
    finish_run();
  end

endmodule